// File: doc/BRIEF.md
# Predicated Vector Integer Reduction Unit

This block collapses a packed vector of integer elements into one 64-bit scalar. A governing predicate with one bit per byte lane selects which elements take part. The operation and the element size come from a 32-bit instruction word that the block decodes itself. It supports signed and unsigned sums, signed and unsigned maxima and minima, and bitwise AND, OR and XOR. Each of these works on byte, halfword, word or doubleword elements. Encodings that are not legal raise an illegal flag and return a zero result.

The caller drives the instruction, the vector and the predicate, and pulses a start strobe for one cycle. The block does not stall, so a new start may come on every cycle. A fixed number of cycles later, the result appears together with a valid flag and the illegal flag. Internally, every element is widened into a 64-bit working lane. A lane that is unused or inactive is replaced with the identity value of the operation. The lanes are then combined by a registered binary tree.

Top module: `red_unit`

## Requirements
- R1: An instruction is legal only if bits 31..24 equal 8'h04, bit 21 is 0 and bits 15..13 equal 3'b001. Any other instruction gives valid_o=1, illegal_o=1 and result_o=0.
- R2: Decoding uses bits 23..22 for the element size (00 byte, 01 halfword, 10 word, 11 doubleword), bits 20..19 for the group and bits 18..16 for the operation code.
  - Group 00 (add): 000 signed sum, 001 unsigned sum.
  - Group 01 (min/max): 000 signed max, 001 unsigned max, 010 signed min, 011 unsigned min.
  - Group 11 (logical): 000 OR, 001 XOR, 010 AND.
  - Group 10, and every code not listed above, is illegal.
- R3: A signed sum on doubleword elements is illegal. An unsigned sum is legal for all four element sizes.
- R4: A signed sum sign-extends each active element to 64 bits, and an unsigned sum zero-extends it. The result is the 64-bit total, which wraps modulo 2^64.
- R5: Signed and unsigned max and min compare elements at their own width. The result is zero-extended from the element width to 64 bits.
- R6: AND, OR and XOR results are as wide as the element and are zero-extended to 64 bits.
- R7: Only active elements count. Element e of an element size of B bytes is active when pred_i[e*B] is 1. The other predicate bits of that element have no effect.
- R8: When no element is active, the result is the identity value of the operation:
  - 0 for a sum, OR, XOR and unsigned max;
  - the all-ones element value for AND and unsigned min;
  - the most positive element value for signed min;
  - the most negative element value for signed max.
- R9: For a start in cycle c, valid_o is high in cycle c+log2(VEC_BITS/8)+1 (cycle c+6 at 256 bits). Starts on consecutive cycles produce results on consecutive cycles, in order.
- R10: While valid_o is low, result_o and illegal_o are 0. After reset, valid_o is 0.
- R11: Instruction bits 12..0, the register number fields, have no effect on the result or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that launches a reduction |
| insn_i | input | 32 | Instruction word to decode |
| vec_i | input | VEC_BITS | Packed source vector, element 0 in the low bits |
| pred_i | input | VEC_BITS/8 | Governing predicate, one bit per byte lane |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | The instruction was not a legal encoding |
| result_o | output | 64 | Scalar result |

## Verification
The hardest cases to reach from the ports are those where a wide element is judged by one byte-lane bit. Examples are a predicate with only odd lanes set, used with halfword elements, or with every lane set except each element's lowest. These are the only cases that show whether the correct predicate bit was chosen, and they also drive the tree to return the identity value. The bench builds these predicates on purpose and repeats them for every operation and size. It also issues starts back to back with pseudo-random data, so that results from neighbouring pipeline stages cannot mix without being caught. A scoreboard compares every result against an element-by-element model that does not use the tree at all.

// File: rtl/red_pkg.sv
// Shared types and helper functions for the vector reduction unit.
// Assumes every working lane is 64 bits wide and that each element is kept
// in the low bits of its lane.
package red_pkg;

    typedef enum logic [3:0] {
        OP_NONE, OP_SADD, OP_UADD, OP_SMAX, OP_UMAX,
        OP_SMIN, OP_UMIN, OP_AND, OP_OR, OP_XOR
    } red_op_e;

    typedef enum logic [1:0] {SZ_B = 2'b00, SZ_H = 2'b01, SZ_W = 2'b10, SZ_D = 2'b11} elem_sz_e;

    typedef struct packed {
        logic     valid;
        logic     illegal;
        red_op_e  op;
        elem_sz_e size;
    } red_ctl_t;

    localparam logic [7:0] MAJOR_CODE = 8'h04;
    localparam logic [2:0] MINOR_CODE = 3'b001;

    // All-ones mask covering one element of the given size.
    function automatic logic [63:0] sz_mask(elem_sz_e s);
        case (s)
            SZ_B:    return 64'h0000_0000_0000_00FF;
            SZ_H:    return 64'h0000_0000_0000_FFFF;
            SZ_W:    return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    // Sign-extend the low element of v to 64 bits.
    function automatic logic [63:0] sx(logic [63:0] v, elem_sz_e s);
        case (s)
            SZ_B:    return {{56{v[7]}}, v[7:0]};
            SZ_H:    return {{48{v[15]}}, v[15:0]};
            SZ_W:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    // Operations that compare or sum with signed extension.
    function automatic logic is_signed(red_op_e op);
        return (op == OP_SADD) || (op == OP_SMAX) || (op == OP_SMIN);
    endfunction

    function automatic logic is_add(red_op_e op);
        return (op == OP_SADD) || (op == OP_UADD);
    endfunction

    // Neutral value of an operation, in working-lane form.
    function automatic logic [63:0] identity(red_op_e op, elem_sz_e s);
        logic [63:0] m;
        m = sz_mask(s);
        case (op)
            OP_SMAX:          return sx(~(m >> 1) & m, s);
            OP_SMIN:          return m >> 1;
            OP_UMIN, OP_AND:  return m;
            default:          return '0;
        endcase
    endfunction

    // Combine two working lanes.
    function automatic logic [63:0] combine(logic [63:0] a, logic [63:0] b, red_op_e op);
        case (op)
            OP_SADD, OP_UADD: return a + b;
            OP_SMAX:          return ($signed(a) > $signed(b)) ? a : b;
            OP_UMAX:          return (a > b) ? a : b;
            OP_SMIN:          return ($signed(a) < $signed(b)) ? a : b;
            OP_UMIN:          return (a < b) ? a : b;
            OP_AND:           return a & b;
            OP_OR:            return a | b;
            OP_XOR:           return a ^ b;
            default:          return a;
        endcase
    endfunction

endpackage

// File: rtl/red_decode.sv
// Instruction decoder for the reduction unit.
// Purely combinational. It checks the fixed fields, maps group and code to an
// operation, and flags every encoding that is not in the table.
// Assumes the register-number fields (bits 12..0) are handled elsewhere.
module red_decode
    import red_pkg::*;
(
    input  logic [31:13] hi_i,
    output red_op_e      op_o,
    output elem_sz_e     size_o,
    output logic         illegal_o
);

    logic       fixed_ok;
    logic [1:0] grp;
    logic [2:0] code;

    assign fixed_ok = (hi_i[31:24] == MAJOR_CODE) && !hi_i[21] && (hi_i[15:13] == MINOR_CODE);
    assign grp      = hi_i[20:19];
    assign code     = hi_i[18:16];
    assign size_o   = elem_sz_e'(hi_i[23:22]);

    // Map the group and code to an operation; anything unmatched is OP_NONE.
    always_comb begin
        op_o = OP_NONE;
        case (grp)
            2'b00: case (code)
                3'b000:  op_o = (size_o == SZ_D) ? OP_NONE : OP_SADD;
                3'b001:  op_o = OP_UADD;
                default: op_o = OP_NONE;
            endcase
            2'b01: case (code)
                3'b000:  op_o = OP_SMAX;
                3'b001:  op_o = OP_UMAX;
                3'b010:  op_o = OP_SMIN;
                3'b011:  op_o = OP_UMIN;
                default: op_o = OP_NONE;
            endcase
            2'b11: case (code)
                3'b000:  op_o = OP_OR;
                3'b001:  op_o = OP_XOR;
                3'b010:  op_o = OP_AND;
                default: op_o = OP_NONE;
            endcase
            default: op_o = OP_NONE;
        endcase
        if (!fixed_ok) begin
            op_o = OP_NONE;
        end
        illegal_o = (op_o == OP_NONE);
    end

endmodule

// File: rtl/red_lane_prep.sv
// Lane preparation stage (first pipeline register).
// Expands the elements of the selected size into NLANE 64-bit working lanes.
// An element is extended by signedness. A lane with no element, or whose
// governing predicate bit is clear, receives the identity value.
// Assumes NLANE is a power of two and at least 8.
module red_lane_prep
    import red_pkg::*;
#(
    parameter int NLANE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  red_op_e            op_i,
    input  elem_sz_e           size_i,
    input  logic               illegal_i,
    input  logic [NLANE*8-1:0] vec_i,
    input  logic [NLANE-1:0]   pred_i,
    output logic [63:0]        lane_o [NLANE],
    output red_ctl_t           ctl_o
);

    localparam int N_H = NLANE / 2;
    localparam int N_W = NLANE / 4;
    localparam int N_D = NLANE / 8;

    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        logic [63:0] rb, rh, rw, rd, raw, ext, lane_d;
        logic        ab, ah, aw, ad, act;

        assign rb = 64'(vec_i[j*8 +: 8]);
        assign ab = pred_i[j];

        if (j < N_H) begin : g_h
            assign rh = 64'(vec_i[j*16 +: 16]);
            assign ah = pred_i[j*2];
        end else begin : g_hn
            assign rh = '0;
            assign ah = 1'b0;
        end

        if (j < N_W) begin : g_w
            assign rw = 64'(vec_i[j*32 +: 32]);
            assign aw = pred_i[j*4];
        end else begin : g_wn
            assign rw = '0;
            assign aw = 1'b0;
        end

        if (j < N_D) begin : g_d
            assign rd = vec_i[j*64 +: 64];
            assign ad = pred_i[j*8];
        end else begin : g_dn
            assign rd = '0;
            assign ad = 1'b0;
        end

        // Pick the element for this size, extend it, or substitute the identity.
        always_comb begin
            case (size_i)
                SZ_B:    begin raw = rb; act = ab; end
                SZ_H:    begin raw = rh; act = ah; end
                SZ_W:    begin raw = rw; act = aw; end
                default: begin raw = rd; act = ad; end
            endcase
            ext    = is_signed(op_i) ? sx(raw, size_i) : raw;
            lane_d = act ? ext : identity(op_i, size_i);
        end

        // Register the prepared lane.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_o[j] <= '0;
            else        lane_o[j] <= lane_d;
        end
    end

    // Register the control that travels with the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_o <= '0;
        else        ctl_o <= '{valid: start_i, illegal: illegal_i, op: op_i, size: size_i};
    end

endmodule

// File: rtl/red_tree.sv
// Registered binary reduction tree.
// Each level halves the number of lanes, with one register per level.
// The control word moves along level by level. Assumes NLANE is a power of two.
module red_tree
    import red_pkg::*;
#(
    parameter int NLANE = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] lane_i [NLANE],
    input  red_ctl_t    ctl_i,
    output logic [63:0] sum_o,
    output red_ctl_t    ctl_o
);

    localparam int LEVELS = $clog2(NLANE);

    for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
        localparam int N = NLANE >> k;
        logic [63:0] src  [2*N];
        logic [63:0] node [N];
        red_ctl_t    cin;
        red_ctl_t    ctl;

        if (k == 1) begin : g_first
            assign src = lane_i;
            assign cin = ctl_i;
        end else begin : g_next
            assign src = g_lvl[k-1].node;
            assign cin = g_lvl[k-1].ctl;
        end

        for (genvar n = 0; n < N; n++) begin : g_node
            // Combine one pair of lanes from the level below.
            always_ff @(posedge clk) begin
                if (!rst_n) node[n] <= '0;
                else        node[n] <= combine(src[2*n], src[2*n+1], cin.op);
            end
        end

        // Carry the control word to this level.
        always_ff @(posedge clk) begin
            if (!rst_n) ctl <= '0;
            else        ctl <= cin;
        end

        if (k == 1) begin : g_chk
            assert_umax_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cin.valid && cin.op == OP_UMAX) |=>
                    (node[0] >= $past(src[0]) && node[0] >= $past(src[1])));

            assert_and_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cin.valid && cin.op == OP_AND) |=>
                    ((node[0] & ~$past(src[0])) == 64'd0));
        end
    end

    assign sum_o = g_lvl[LEVELS].node[0];
    assign ctl_o = g_lvl[LEVELS].ctl;

endmodule

// File: rtl/red_unit.sv
// Predicated vector integer reduction unit (top).
// Decodes the instruction, prepares the working lanes and reduces them in a
// registered tree. It then narrows the result to the element width for all
// operations except the sums. Latency is log2(VEC_BITS/8)+1 cycles from start.
// Assumes VEC_BITS is a power of two and at least 64.
module red_unit
    import red_pkg::*;
#(
    parameter int VEC_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [31:0]           insn_i,
    input  logic [VEC_BITS-1:0]   vec_i,
    input  logic [VEC_BITS/8-1:0] pred_i,
    output logic                  valid_o,
    output logic                  illegal_o,
    output logic [63:0]           result_o
);

    localparam int NLANE = VEC_BITS / 8;
    localparam int LAT   = $clog2(NLANE) + 1;

    red_op_e     dec_op;
    elem_sz_e    dec_size;
    logic        dec_illegal;
    logic [63:0] lanes [NLANE];
    red_ctl_t    prep_ctl;
    logic [63:0] tree_sum;
    red_ctl_t    tree_ctl;

    red_decode u_decode (
        .hi_i      (insn_i[31:13]),
        .op_o      (dec_op),
        .size_o    (dec_size),
        .illegal_o (dec_illegal)
    );

    red_lane_prep #(.NLANE(NLANE)) u_prep (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (dec_op),
        .size_i    (dec_size),
        .illegal_i (dec_illegal),
        .vec_i     (vec_i),
        .pred_i    (pred_i),
        .lane_o    (lanes),
        .ctl_o     (prep_ctl)
    );

    red_tree #(.NLANE(NLANE)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .lane_i(lanes),
        .ctl_i (prep_ctl),
        .sum_o (tree_sum),
        .ctl_o (tree_ctl)
    );

    // Narrow the tree output and gate it with the valid and illegal flags.
    always_comb begin
        valid_o   = tree_ctl.valid;
        illegal_o = tree_ctl.valid && tree_ctl.illegal;
        if (!tree_ctl.valid || tree_ctl.illegal)  result_o = '0;
        else if (is_add(tree_ctl.op))             result_o = tree_sum;
        else                                      result_o = tree_sum & sz_mask(tree_ctl.size);
    end

    // Count cycles since reset, saturating, so the latency check starts only after the pipeline has refilled.
    logic [7:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_rst <= '0;
        else if (since_rst < 8'(LAT))  since_rst <= since_rst + 8'd1;
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 8'(LAT)) |-> (valid_o == $past(start_i, LAT)));

    assert_fixed_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (insn_i[31:24] != 8'h04 || insn_i[21] || insn_i[15:13] != 3'b001))
            |-> ##LAT (valid_o && illegal_o && result_o == 64'd0));

    assert_group_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && insn_i[20:19] == 2'b10) |-> ##LAT illegal_o);

    assert_sadd_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && insn_i[31:24] == 8'h04 && !insn_i[21] && insn_i[15:13] == 3'b001 &&
         insn_i[23:22] == 2'b11 && insn_i[20:16] == 5'b00000) |-> ##LAT illegal_o);

    assert_operand_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[31:13] == $past(insn_i[31:13]) && insn_i[12:0] != $past(insn_i[12:0]))
            |-> (dec_op == $past(dec_op) && dec_illegal == $past(dec_illegal)));

endmodule

// File: tb/red_unit_tb_top.sv
// Scoreboard bench: a driver task pushes the expected results, and a monitor
// pops them and compares them with what the design produces.
module red_unit_tb_top;
    localparam int VB  = 256;
    localparam int NL  = VB / 8;
    localparam int LAT = $clog2(NL) + 1;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [31:0]   insn = '0;
    logic [VB-1:0] vec = '0;
    logic [NL-1:0] pred = '0;
    logic          valid_o, illegal_o;
    logic [63:0]   result_o;

    red_unit #(.VEC_BITS(VB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .insn_i(insn),
        .vec_i(vec), .pred_i(pred),
        .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [63:0] res;
        logic        ill;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0, n_chk = 0, n_fail = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk(logic [1:0] sz, logic [1:0] grp, logic [2:0] code);
        return {8'h04, sz, 1'b0, grp, code, 3'b001, 3'd7, 5'd31, 5'd0};
    endfunction

    // Reference model: walks the elements one by one.
    function automatic void model(input logic [31:0] ins, input logic [VB-1:0] v,
                                  input logic [NL-1:0] p,
                                  output logic [63:0] r, output logic il);
        int sz, grp, code, bytes, w, kind;
        logic [63:0] m, acc, x, xs;
        sz = int'(ins[23:22]); grp = int'(ins[20:19]); code = int'(ins[18:16]);
        bytes = 1 << sz; w = 8 * bytes;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        kind = 0;
        if (ins[31:24] == 8'h04 && !ins[21] && ins[15:13] == 3'b001) begin
            if (grp == 0 && code == 0 && sz != 3) kind = 1;
            if (grp == 0 && code == 1) kind = 2;
            if (grp == 1 && code <= 3) kind = 3 + code;
            if (grp == 3 && code == 0) kind = 8;
            if (grp == 3 && code == 1) kind = 9;
            if (grp == 3 && code == 2) kind = 7;
        end
        case (kind)
            3: acc = ~(m >> 1);
            5: acc = m >> 1;
            6, 7: acc = m;
            default: acc = '0;
        endcase
        for (int e = 0; e < NL / bytes; e++) begin
            if (p[e*bytes]) begin
                x  = 64'(v >> (e * w)) & m;
                xs = x[w-1] ? (x | ~m) : x;
                case (kind)
                    1: acc = acc + xs;
                    2: acc = acc + x;
                    3: if ($signed(xs) > $signed(acc)) acc = xs;
                    4: if (x > acc) acc = x;
                    5: if ($signed(xs) < $signed(acc)) acc = xs;
                    6: if (x < acc) acc = x;
                    7: acc = acc & x;
                    8: acc = acc | x;
                    9: acc = acc ^ x;
                    default: ;
                endcase
            end
        end
        il = (kind == 0);
        if (il)                     r = '0;
        else if (kind <= 2)         r = acc;
        else                        r = acc & m;
    endfunction

    // Drive one start at the current falling edge and queue its expectation.
    task automatic issue(logic [31:0] i, logic [VB-1:0] v, logic [NL-1:0] p, string tag);
        exp_t e;
        model(i, v, p, e.res, e.ill);
        e.due = cyc + LAT; e.tag = tag;
        insn = i; vec = v; pred = p; start = 1'b1;
        q.push_back(e);
    endtask

    task automatic send(logic [31:0] i, logic [VB-1:0] v, logic [NL-1:0] p, string tag);
        @(negedge clk);
        issue(i, v, p, tag);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Check a hand-computed value against the model before queueing.
    task automatic send_x(logic [31:0] i, logic [VB-1:0] v, logic [NL-1:0] p,
                          logic [63:0] xr, logic xi, string tag);
        logic [63:0] mr; logic mi;
        model(i, v, p, mr, mi);
        chk(mr == xr && mi == xi, {tag, " hand value"}, mr, xr);
        send(i, v, p, tag);
    endtask

    // Monitor: compare each valid result with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (valid_o) begin
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected valid", result_o, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.due, {"R9 latency ", e.tag}, 64'(cyc), 64'(e.due));
                    chk(result_o == e.res, {"result ", e.tag}, result_o, e.res);
                    chk(illegal_o == e.ill, {"illegal flag ", e.tag}, 64'(illegal_o), 64'(e.ill));
                end
            end else if (result_o != 0 || illegal_o) begin
                chk(0, "R10 idle outputs", result_o, 64'd0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    function automatic logic [VB-1:0] rnd_vec();
        logic [VB-1:0] v;
        for (int k = 0; k < VB / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [VB-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 0 && result_o == 0 && illegal_o == 0, "R10 reset state", result_o, 64'd0);

        // R4: sums of all-0xFF bytes, signed and unsigned.
        send_x(mk(2'b00, 2'b00, 3'b001), '1, '1, 64'd8160, 1'b0, "R4 uadd bytes");
        send_x(mk(2'b00, 2'b00, 3'b000), '1, '1, 64'hFFFF_FFFF_FFFF_FFE0, 1'b0, "R4 sadd bytes");
        send(mk(2'b01, 2'b00, 3'b000), rnd_vec(), '1, "R4 sadd half");
        send(mk(2'b10, 2'b00, 3'b000), rnd_vec(), '1, "R4 sadd word");
        send(mk(2'b11, 2'b00, 3'b001), '1, '1, "R3 R4 uadd double wrap");
        send_x(mk(2'b11, 2'b00, 3'b000), '1, '1, 64'd0, 1'b1, "R3 sadd double illegal");

        // R5 and R6: every comparison and logical code at every size.
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) send(mk(2'(s), 2'b01, 3'(c)), rnd_vec(), '1, "R5 minmax");
            for (int c = 0; c < 3; c++) send(mk(2'(s), 2'b11, 3'(c)), rnd_vec(), '1, "R6 logical");
        end
        v = '0; v[7:0] = 8'h80; v[15:8] = 8'h7F;
        send_x(mk(2'b00, 2'b01, 3'b000), v, 32'h3, 64'h7F, 1'b0, "R5 smax byte");
        send_x(mk(2'b00, 2'b01, 3'b010), v, 32'h3, 64'h80, 1'b0, "R5 smin byte");

        // R7 and R8: predicates that reach only non-lowest lanes, or none at all.
        for (int s = 1; s < 4; s++) begin
            for (int c = 0; c < 4; c++) send(mk(2'(s), 2'b01, 3'(c)), rnd_vec(), 32'hAAAA_AAAA, "R7 odd lanes only");
            send(mk(2'(s), 2'b11, 3'b010), rnd_vec(), 32'hFEFE_FEFE, "R7 and without low lanes");
        end
        send_x(mk(2'b01, 2'b01, 3'b000), rnd_vec(), 32'hAAAA_AAAA, 64'h8000, 1'b0, "R8 smax half identity");
        for (int s = 0; s < 4; s++) begin
            send(mk(2'(s), 2'b00, 3'b001), rnd_vec(), '0, "R8 sum identity");
            for (int c = 0; c < 4; c++) send(mk(2'(s), 2'b01, 3'(c)), rnd_vec(), '0, "R8 minmax identity");
            for (int c = 0; c < 3; c++) send(mk(2'(s), 2'b11, 3'(c)), rnd_vec(), '0, "R8 logical identity");
        end
        send(mk(2'b10, 2'b01, 3'b001), rnd_vec(), 32'h0000_0100, "R7 single word element");

        // R1: fixed-field mismatches.
        send_x(mk(2'b00, 2'b00, 3'b001) ^ 32'h0100_0000, '1, '1, 64'd0, 1'b1, "R1 major code");
        send_x(mk(2'b00, 2'b00, 3'b001) | 32'h0020_0000, '1, '1, 64'd0, 1'b1, "R1 bit 21");
        send_x(mk(2'b00, 2'b00, 3'b001) ^ 32'h0000_4000, '1, '1, 64'd0, 1'b1, "R1 minor code");

        // R2: codes not in the table.
        send_x(mk(2'b00, 2'b10, 3'b000), '1, '1, 64'd0, 1'b1, "R2 group 10");
        send_x(mk(2'b00, 2'b00, 3'b010), '1, '1, 64'd0, 1'b1, "R2 add code 010");
        send_x(mk(2'b01, 2'b01, 3'b100), '1, '1, 64'd0, 1'b1, "R2 minmax code 100");
        send_x(mk(2'b10, 2'b11, 3'b011), '1, '1, 64'd0, 1'b1, "R2 logical code 011");

        // R11: register fields vary, result must not.
        v = rnd_vec();
        send(mk(2'b00, 2'b00, 3'b001), v, 32'h5A5A_5A5A, "R11 fields base");
        send(mk(2'b00, 2'b00, 3'b001) ^ 32'h0000_1FFF, v, 32'h5A5A_5A5A, "R11 fields flipped");
        send(mk(2'b11, 2'b00, 3'b000) & 32'hFFFF_E000, v, '1, "R11 illegal zero fields");

        // R9: back-to-back starts with mixed operations.
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            logic [1:0] gs[3];
            logic [1:0] g;
            gs[0] = 2'b00; gs[1] = 2'b01; gs[2] = 2'b11;
            g = gs[k % 3];
            issue(mk(2'(k), g, 3'(($urandom % 4))), rnd_vec(), NL'($urandom), "R9 back-to-back");
            @(negedge clk);
        end
        start = 1'b0;

        repeat (LAT + 4) @(negedge clk);
        chk(q.size() == 0, "R9 all results returned", 64'(q.size()), 64'd0);
        summary();
    end
endmodule